// File: doc/BRIEF.md
# Vertical Blank Flag and NMI Request Unit

This block owns the vertical-blank status flag of a video timing unit, the byte returned when the CPU reads the status register, and the active-high NMI request line. An external timing generator supplies the current scanline and dot numbers on every dot clock. The CPU side supplies a status-read strobe and a register-write strobe with a select for the control register, whose bit 7 enables NMI.

The flag rises at a fixed point near the start of the blanking interval and falls at the start of the pre-render line. A status read clears the flag and drops the NMI request. It also pulses a clear for the shared address write-toggle latch elsewhere in the video unit. A status read that comes within one dot of the flag-set point is a race. The block resolves it deterministically and suppresses the NMI for the rest of that frame. The upper three bits of the returned byte are status bits. The lower five bits come from an open-bus latch, which the block keeps up to date.

Top module: `vbl_nmi_unit`

## Requirements
- R1: While `rst` is high and in the cycle after it, `nmi_req`, `toggle_clr` and `rd_data` are all zero, NMI is disabled, and the flag is clear.
- R2: The flag is set when the dot clock at scanline 241, dot 1 completes. It stays set until a status read, or until the clock at scanline 261, dot 1 completes.
- R3: A status read at scanline 241, dot 0 returns bit 7 as 0. The flag is then not set in that frame and `nmi_req` stays low.
- R4: A status read at scanline 241, dot 1 or dot 2 returns bit 7 as 1 and leaves the flag clear. `nmi_req` does not rise in that frame.
- R5: After any status read, the flag is clear, `nmi_req` is low and `toggle_clr` is high for exactly one cycle.
- R6: One cycle after a read, `rd_data` is {flag, `evt_flags[1:0]`, open-bus latch bits 4:0}, where the flag is the value seen at the read dot. The open-bus latch then holds this returned byte.
- R7: A write with `wr_ctrl` high loads `wr_data[7]` as the NMI enable. With NMI enabled and no suppression, `nmi_req` rises one cycle after the flag, that is, after the clock at scanline 241, dot 2.
- R8: `nmi_req` is high exactly when the flag is set and NMI is enabled, outside the set dot. Enabling NMI while the flag is set raises `nmi_req` on the next cycle. Disabling it drops `nmi_req` on the next cycle.
- R9: Suppression caused by a race read lasts until scanline 261, dot 1. The next frame sets the flag and raises the NMI normally.
- R10: Every register write loads `wr_data` into the open-bus latch, which bits 4:0 of later reads return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| line | input | 9 | Current scanline from the timing generator |
| dot | input | 9 | Current dot within the scanline |
| status_rd | input | 1 | One-cycle strobe: CPU reads the status register |
| wr_stb | input | 1 | One-cycle strobe: CPU writes any video register |
| wr_ctrl | input | 1 | With `wr_stb`, the write targets the control register |
| wr_data | input | 8 | Write data; bit 7 is NMI enable for control writes |
| evt_flags | input | 2 | Status bits 6:5 from the sprite logic |
| rd_data | output | 8 | Registered status byte for the last read |
| nmi_req | output | 1 | Active-high NMI request |
| toggle_clr | output | 1 | One-cycle pulse that clears the address write toggle |

## Verification
The assertions assume that the timing inputs change at most once per clock and that `status_rd` and `wr_stb` are never high in the same cycle. They do not require `line` and `dot` to advance contiguously. The bench therefore jumps straight to the dots of interest around scanlines 241 and 261 instead of playing whole frames. It keeps read and write strobes mutually exclusive in both the directed phases and the random phase. Dot values in the random phase cluster around the set and clear points, so the race window is hit often.

// File: rtl/vbl_pkg.sv
package vbl_pkg;
  // Open-bus latch field split: upper bits come from status, lower from the latch.
  localparam int STAT_BITS = 3;
  localparam int BUS_W     = 8;
  localparam int OPEN_BITS = BUS_W - STAT_BITS;

  typedef struct packed {
    logic                 vblank;
    logic [1:0]           evt;
    logic [OPEN_BITS-1:0] open_bus;
  } status_byte_t;

  // True when a read at dot d falls within one dot of the set point.
  function automatic logic in_race(input int d, input int set_dot);
    return (d >= set_dot - 1) && (d <= set_dot + 1);
  endfunction
endpackage

// File: rtl/vbl_flag_ctrl.sv
module vbl_flag_ctrl #(
  parameter int SL_W     = 9,
  parameter int DOT_W    = 9,
  parameter int VBL_LINE = 241,
  parameter int PRE_LINE = 261,
  parameter int SET_DOT  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SL_W-1:0]  line,
  input  logic [DOT_W-1:0] dot,
  input  logic             rd,
  output logic             vbl_q,
  output logic             vbl_d,
  output logic             flag_view,
  output logic             at_set
);
  import vbl_pkg::*;

  logic at_clr, race, supp_q, supp_d;

  assign at_set    = (int'(line) == VBL_LINE) && (int'(dot) == SET_DOT);
  assign at_clr    = (int'(line) == PRE_LINE) && (int'(dot) == SET_DOT);
  assign race      = rd && (int'(line) == VBL_LINE) && in_race(int'(dot), SET_DOT);
  // Value a read on this dot observes: a read on the set dot sees it set.
  assign flag_view = vbl_q || (at_set && !supp_q);

  always_comb begin
    supp_d = supp_q;
    if (at_clr)    supp_d = 1'b0;
    else if (race) supp_d = 1'b1;

    vbl_d = vbl_q;
    if (rd || at_clr)            vbl_d = 1'b0;
    else if (at_set && !supp_q)  vbl_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vbl_q  <= 1'b0;
      supp_q <= 1'b0;
    end else begin
      vbl_q  <= vbl_d;
      supp_q <= supp_d;
    end
  end

  // R2
  vbl_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vbl_q) |-> $past(at_set));
  // R5
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    rd |=> !vbl_q);
  // R3
  supp_block_chk: assert property (@(posedge clk) disable iff (rst)
    (supp_q && at_set) |=> !vbl_q);
  // R9
  frame_clr_chk: assert property (@(posedge clk) disable iff (rst)
    at_clr |=> (!vbl_q && !supp_q));
endmodule

// File: rtl/nmi_drive.sv
module nmi_drive (
  input  logic clk,
  input  logic rst,
  input  logic wr_stb,
  input  logic wr_ctrl,
  input  logic en_bit,
  input  logic vbl_q,
  input  logic vbl_d,
  input  logic at_set,
  output logic nmi_req
);
  logic en_q, en_d, nmi_q;

  assign en_d = (wr_stb && wr_ctrl) ? en_bit : en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      // Held back on the set dot so a race read one dot later leaves no glitch.
      nmi_q <= vbl_d && en_d && !at_set;
    end
  end

  assign nmi_req = nmi_q;

  // R8
  nmi_flag_chk: assert property (@(posedge clk) disable iff (rst)
    nmi_q |-> (vbl_q && en_q));
  // R8
  en_off_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_ctrl && !en_bit) |=> !nmi_q);
endmodule

// File: rtl/status_port.sv
module status_port (
  input  logic       clk,
  input  logic       rst,
  input  logic       rd,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  input  logic       flag_view,
  input  logic [1:0] evt_flags,
  output logic [7:0] rd_data,
  output logic       toggle_clr
);
  import vbl_pkg::*;

  logic [BUS_W-1:0] latch_q, rdata_q;
  status_byte_t     ret;

  always_comb begin
    ret.vblank   = flag_view;
    ret.evt      = evt_flags;
    ret.open_bus = latch_q[OPEN_BITS-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q    <= '0;
      rdata_q    <= '0;
      toggle_clr <= 1'b0;
    end else begin
      toggle_clr <= rd;
      if (rd) begin
        rdata_q <= ret;
        latch_q <= ret;
      end else if (wr_stb) begin
        latch_q <= wr_data;
      end
    end
  end

  assign rd_data = rdata_q;

  // R6
  latch_ret_chk: assert property (@(posedge clk) disable iff (rst)
    rd |=> (latch_q == rdata_q));
  // R5
  toggle_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rd |=> toggle_clr);
endmodule

// File: rtl/vbl_nmi_unit.sv
module vbl_nmi_unit #(
  parameter int SL_W     = 9,
  parameter int DOT_W    = 9,
  parameter int VBL_LINE = 241,
  parameter int PRE_LINE = 261,
  parameter int SET_DOT  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SL_W-1:0]  line,
  input  logic [DOT_W-1:0] dot,
  input  logic             status_rd,
  input  logic             wr_stb,
  input  logic             wr_ctrl,
  input  logic [7:0]       wr_data,
  input  logic [1:0]       evt_flags,
  output logic [7:0]       rd_data,
  output logic             nmi_req,
  output logic             toggle_clr
);
  logic vbl_q, vbl_d, flag_view, at_set;

  vbl_flag_ctrl #(
    .SL_W(SL_W), .DOT_W(DOT_W), .VBL_LINE(VBL_LINE),
    .PRE_LINE(PRE_LINE), .SET_DOT(SET_DOT)
  ) u_flag (
    .clk(clk), .rst(rst), .line(line), .dot(dot), .rd(status_rd),
    .vbl_q(vbl_q), .vbl_d(vbl_d), .flag_view(flag_view), .at_set(at_set)
  );

  nmi_drive u_nmi (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_ctrl(wr_ctrl),
    .en_bit(wr_data[7]), .vbl_q(vbl_q), .vbl_d(vbl_d), .at_set(at_set),
    .nmi_req(nmi_req)
  );

  status_port u_port (
    .clk(clk), .rst(rst), .rd(status_rd), .wr_stb(wr_stb), .wr_data(wr_data),
    .flag_view(flag_view), .evt_flags(evt_flags),
    .rd_data(rd_data), .toggle_clr(toggle_clr)
  );

  // R5
  rd_nmi_drop_chk: assert property (@(posedge clk) disable iff (rst)
    status_rd |=> !nmi_req);
endmodule

// File: tb/vbl_nmi_unit_test.sv
`timescale 1ns/1ps
module vbl_nmi_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] line = '0, dot = '0;
  logic       status_rd = 1'b0, wr_stb = 1'b0, wr_ctrl = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] evt_flags = '0;
  logic [7:0] rd_data;
  logic       nmi_req, toggle_clr;

  int compared = 0, mismatched = 0;

  // reference state
  bit       m_vbl, m_supp, m_en, m_nmi, m_tog;
  bit [7:0] m_latch, m_rdata;

  always #2 clk = ~clk;

  vbl_nmi_unit uut (
    .clk(clk), .rst(rst), .line(line), .dot(dot), .status_rd(status_rd),
    .wr_stb(wr_stb), .wr_ctrl(wr_ctrl), .wr_data(wr_data), .evt_flags(evt_flags),
    .rd_data(rd_data), .nmi_req(nmi_req), .toggle_clr(toggle_clr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk({tag, " nmi_req"}, nmi_req, m_nmi);
    chk({tag, " toggle_clr"}, toggle_clr, m_tog);
    chk({tag, " rd_data"}, rd_data, m_rdata);
  endtask

  task automatic model_step();
    bit set_pt, clr_pt, view, race;
    set_pt = (line == 241) && (dot == 1);
    clr_pt = (line == 261) && (dot == 1);
    view   = m_vbl || (set_pt && !m_supp);
    race   = status_rd && (line == 241) && (dot <= 2);
    if (status_rd) begin
      m_rdata = {view, evt_flags, m_latch[4:0]};
      m_latch = m_rdata;
    end else if (wr_stb) m_latch = wr_data;
    m_tog = status_rd;
    if (wr_stb && wr_ctrl) m_en = wr_data[7];
    if (status_rd || clr_pt) m_vbl = 0;
    else if (set_pt && !m_supp) m_vbl = 1;
    if (clr_pt) m_supp = 0;
    else if (race) m_supp = 1;
    m_nmi = m_vbl && m_en && !set_pt;
  endtask

  task automatic step(input string tag, input int l, input int d,
                      input bit rd = 0, input bit wr = 0, input bit ctl = 0,
                      input bit [7:0] data = 8'h00);
    line = 9'(l); dot = 9'(d); status_rd = rd; wr_stb = wr; wr_ctrl = ctl; wr_data = data;
    @(posedge clk);
    model_step();
    #1;
    compare_all(tag);
    status_rd = 0; wr_stb = 0; wr_ctrl = 0;
  endtask

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 nmi", nmi_req, 0); chk("R1 tog", toggle_clr, 0); chk("R1 data", rd_data, 0);
    rst = 0;
    step("R1", 10, 5);
    chk("R1 after", nmi_req, 0);

    // R7 enable, normal frame
    step("R7 en", 100, 0, 0, 1, 1, 8'h80);
    step("R7", 241, 0);
    step("R7", 241, 1);
    chk("R7 not yet", nmi_req, 0);
    step("R7", 241, 2);
    chk("R7 rise", nmi_req, 1);
    step("R2", 241, 3);
    chk("R2 hold", nmi_req, 1);
    // R5 read clears
    step("R5 rd", 241, 10, 1);
    chk("R5 bit7", rd_data[7], 1);
    chk("R5 nmi", nmi_req, 0);
    chk("R5 tog", toggle_clr, 1);
    step("R5", 241, 11);
    chk("R5 tog pulse", toggle_clr, 0);

    // R8 enable while flag set
    step("R2", 261, 1);
    step("R8 off", 100, 0, 0, 1, 1, 8'h00);
    step("R8", 241, 1);
    step("R8", 241, 2);
    chk("R8 disabled", nmi_req, 0);
    step("R8 on", 241, 20, 0, 1, 1, 8'h80);
    chk("R8 raise", nmi_req, 1);
    step("R8 off", 241, 21, 0, 1, 1, 8'h00);
    chk("R8 drop", nmi_req, 0);
    step("R8 on", 241, 22, 0, 1, 1, 8'h80);
    step("R2 clr", 261, 1);
    chk("R2 clear", nmi_req, 0);
    step("R2 rd", 261, 5, 1);
    chk("R2 cleared flag", rd_data[7], 0);

    // R3 race at dot 0
    step("R3 rd", 241, 0, 1);
    chk("R3 bit7", rd_data[7], 0);
    for (int d = 1; d < 6; d++) step("R3", 241, d);
    chk("R3 no nmi", nmi_req, 0);
    step("R3 rd", 241, 6, 1);
    chk("R3 flag never set", rd_data[7], 0);

    // R9 next frame is normal
    step("R9", 261, 1);
    step("R9", 241, 1);
    step("R9", 241, 2);
    chk("R9 nmi back", nmi_req, 1);

    // R4 race at dot 1 and dot 2
    for (int k = 1; k <= 2; k++) begin
      step("R4", 261, 1);
      if (k == 2) step("R4", 241, 1);
      step("R4 rd", 241, k, 1);
      chk("R4 bit7", rd_data[7], 1);
      for (int d = k + 1; d < 8; d++) begin
        step("R4", 241, d);
        chk("R4 no nmi", nmi_req, 0);
      end
    end

    // R10 / R6 latch and fields
    evt_flags = 2'b10;
    step("R10 wr", 50, 50, 0, 1, 0, 8'h15);
    step("R6 rd", 50, 51, 1);
    chk("R6 byte", rd_data, 8'h55);
    evt_flags = 2'b01;
    step("R6 rd2", 50, 52, 1);
    chk("R6 latch reuse", rd_data, 8'h35);

    // random phase, all requirements compared every cycle
    for (int i = 0; i < 3000; i++) begin
      int pick, l, d;
      bit rd, wr;
      pick = $urandom_range(0, 9);
      l = (pick < 5) ? 241 : (pick < 7) ? 261 : $urandom_range(0, 260);
      d = (pick < 7) ? $urandom_range(0, 4) : $urandom_range(0, 340);
      rd = ($urandom_range(0, 5) == 0);
      wr = !rd && ($urandom_range(0, 5) == 0);
      evt_flags = 2'($urandom_range(0, 3));
      step("R1-rand R2 R3 R4 R5 R6 R7 R8 R9 R10", l, d, rd, wr,
           bit'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule